// File: doc/BRIEF.md
# Watchdog Second-Timeout Status Controller

This block keeps the status word of a two-stage system watchdog and acts when the watchdog expires a second time. The countdown timer outside the block sends a one-cycle expiry pulse each time it runs out and a reload strobe each time software services it. The block tracks internally whether the first stage has already expired. If a second expiry arrives before any reload, it latches a second-timeout flag. It can then request a platform reset of fixed length and, if the processor never fetched its first instruction, ask for the safe all-ones frequency multiplier during that reboot.

Two further event flags share the word. One records a non-maskable wake from the management engine and holds a wake-to-S0 request while it is set. The other records an SMI message that arrived on the slave link. Every flag is set by hardware only and cleared by software writing a one to it. The block has two resets. The resume-well reset clears everything. The warm hard reset only drops the first-stage tracking and any reboot pulse in progress, so all recorded flags survive it.

Top module: `wdt_status_ctrl`

## Requirements
- R1: After the resume-well reset, the register reads 16'h0000 and plat_rst_req, wake_s0_req and mult_sel are all 0.
- R2: Bits 15:6, bit 3 and bit 0 always read 0, and writing ones to them changes nothing.
- R3: The first expiry only arms the internal first stage, so bit 1 stays 0. A second expiry with no reload in between sets bit 1 (second timeout) on the edge where it is sampled, and it disarms the first stage.
- R4: A reload strobe disarms the first stage. An expiry in the same cycle as a reload is ignored.
- R5: Writing 1 to bit 1, 4 or 5 clears that bit and writing 0 leaves it. A hardware set in the same cycle as a clearing write wins.
- R6: Bit 2 (boot failure) sets together with a 0-to-1 change of bit 1 only when cpu_fetched is 0.
- R7: A write of 1 to bit 2 is ignored while bit 1 is set, even when the same write clears bit 1.
- R8: Each second-timeout event with no_reboot at 0 produces exactly one plat_rst_req pulse of 16 cycles, starting the cycle after the expiry. With no_reboot at 1 there is no pulse.
- R9: mult_sel is 4'b1111 while plat_rst_req is high and bit 2 is set, and 4'b0000 otherwise.
- R10: A me_wake_evt pulse sets bit 5, and wake_s0_req equals bit 5.
- R11: An smi_msg_evt pulse sets bit 4.
- R12: A warm hard reset ends a running reboot pulse and disarms the first stage, but keeps bits 1, 2, 4 and 5. The resume-well reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rsm_rst_n | input | 1 | Resume-well reset, active low, asynchronous assert |
| hard_rst_n | input | 1 | Warm hard reset, active low, asynchronous assert |
| wdt_expire | input | 1 | One-cycle watchdog expiry pulse |
| wdt_reload | input | 1 | Watchdog reload strobe |
| cpu_fetched | input | 1 | Processor has fetched its first instruction |
| no_reboot | input | 1 | Suppresses the reboot on second timeout |
| me_wake_evt | input | 1 | Non-maskable wake event pulse |
| smi_msg_evt | input | 1 | SMI message received pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Write data, ones clear flags |
| reg_rdata | output | 16 | Status word |
| plat_rst_req | output | 1 | Platform reset request pulse |
| wake_s0_req | output | 1 | Wake-to-S0 request |
| mult_sel | output | 4 | Safe multiplier select, all ones when forced |

## Verification
The hardest state to reach is a reboot in which boot failure is set, followed by a warm reset that lands in the middle of the 16-cycle pulse. The bench holds cpu_fetched low, sends two expiries back to back, and drops hard_rst_n a few cycles into the pulse. The disarm rule needs a similar two-step approach. The bench arms the first stage, applies a warm reset, and then shows that one more expiry does not complete a second timeout. The ordering rule between bits 1 and 2 is reached with one write that clears both bits together.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned MULT_W   = 4;
  localparam int unsigned BIT_SEC  = 1;
  localparam int unsigned BIT_BOOT = 2;
  localparam int unsigned BIT_SMI  = 4;
  localparam int unsigned BIT_ME   = 5;

  typedef struct packed {
    logic me;
    logic smi;
    logic boot;
    logic sec;
  } wdt_stat_t;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdt_stage_track.sv
module wdt_stage_track (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic reload,
  output logic sec_evt
);
  logic pend_q, pend_d, pend_en;

  always_comb begin
    pend_d  = pend_q;
    pend_en = reload | expire;
    if (reload)      pend_d = 1'b0;
    else if (expire) pend_d = ~pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (pend_en) pend_q <= pend_d;
  end

  assign sec_evt = expire & pend_q & ~reload;

  a_r4_reload_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> !pend_q);
  a_r3_second_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> !pend_q);
endmodule

// File: rtl/wdt_status_bits.sv
module wdt_status_bits
  import wdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_set,
  input  logic      fetched,
  input  logic      me_set,
  input  logic      smi_set,
  input  wdt_stat_t clr,
  output wdt_stat_t stat
);
  wdt_stat_t q, d;
  logic      upd;

  always_comb begin
    d.sec  = sec_set | (q.sec & ~clr.sec);
    d.boot = (sec_set & ~q.sec & ~fetched) | (q.boot & ~(clr.boot & ~q.sec));
    d.smi  = smi_set | (q.smi & ~clr.smi);
    d.me   = me_set  | (q.me  & ~clr.me);
    upd    = sec_set | me_set | smi_set | (|clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= d;
  end

  assign stat = q;

  a_r3_sec_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sec_set |=> q.sec);
  a_r6_boot_with_sec: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q.boot) |-> $rose(q.sec));
  a_r7_boot_held: assert property (@(posedge clk) disable iff (!rst_n)
    (q.boot && q.sec) |=> q.boot);
  a_r10_me_sets: assert property (@(posedge clk) disable iff (!rst_n)
    me_set |=> q.me);
  a_r11_smi_sets: assert property (@(posedge clk) disable iff (!rst_n)
    smi_set |=> q.smi);
endmodule

// File: rtl/wdt_reboot_pulse.sv
module wdt_reboot_pulse #(
  parameter int unsigned PULSE_W = 16,
  parameter int unsigned MULT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_evt,
  input  logic              no_reboot,
  input  logic              boot_flag,
  output logic              rst_req,
  output logic [MULT_W-1:0] mult_sel
);
  localparam int unsigned CW = $clog2(PULSE_W + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_W);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          active, trig, cnt_en;

  assign active = (cnt_q != '0);
  assign trig   = sec_evt & ~no_reboot & ~active;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = trig | active;
    if (trig)        cnt_d = LOAD;
    else if (active) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign rst_req  = active;
  assign mult_sel = (active && boot_flag) ? '1 : '0;

  a_r8_starts: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (cnt_q == LOAD));
  a_r8_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (no_reboot && !active) |=> !rst_req);
endmodule

// File: rtl/wdt_reg_port.sv
module wdt_reg_port
  import wdt_pkg::*;
(
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  input  wdt_stat_t        stat,
  output wdt_stat_t        clr,
  output logic [REG_W-1:0] rdata
);
  always_comb begin
    clr.sec  = wr & wdata[BIT_SEC];
    clr.boot = wr & wdata[BIT_BOOT];
    clr.smi  = wr & wdata[BIT_SMI];
    clr.me   = wr & wdata[BIT_ME];
    rdata            = '0;
    rdata[BIT_SEC]   = stat.sec;
    rdata[BIT_BOOT]  = stat.boot;
    rdata[BIT_SMI]   = stat.smi;
    rdata[BIT_ME]    = stat.me;
  end
endmodule

// File: rtl/wdt_status_ctrl.sv
module wdt_status_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned PULSE_W     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rsm_rst_n,
  input  logic              hard_rst_n,
  input  logic              wdt_expire,
  input  logic              wdt_reload,
  input  logic              cpu_fetched,
  input  logic              no_reboot,
  input  logic              me_wake_evt,
  input  logic              smi_msg_evt,
  input  logic              reg_wr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              plat_rst_req,
  output logic              wake_s0_req,
  output logic [3:0]        mult_sel
);
  logic      rsm_sync_n, warm_sync_n, warm_arst_n, sec_evt;
  wdt_stat_t stat, clr;

  assign warm_arst_n = rsm_rst_n & hard_rst_n;

  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_rsm_sync (
    .clk(clk), .arst_n(rsm_rst_n), .srst_n(rsm_sync_n));
  wdt_rst_sync #(.STAGES(SYNC_STAGES)) u_warm_sync (
    .clk(clk), .arst_n(warm_arst_n), .srst_n(warm_sync_n));

  wdt_stage_track u_stage (
    .clk(clk), .rst_n(warm_sync_n), .expire(wdt_expire),
    .reload(wdt_reload), .sec_evt(sec_evt));

  wdt_status_bits u_bits (
    .clk(clk), .rst_n(rsm_sync_n), .sec_set(sec_evt), .fetched(cpu_fetched),
    .me_set(me_wake_evt), .smi_set(smi_msg_evt), .clr(clr), .stat(stat));

  wdt_reboot_pulse #(.PULSE_W(PULSE_W), .MULT_W(MULT_W)) u_pulse (
    .clk(clk), .rst_n(warm_sync_n), .sec_evt(sec_evt), .no_reboot(no_reboot),
    .boot_flag(stat.boot), .rst_req(plat_rst_req), .mult_sel(mult_sel));

  wdt_reg_port u_port (
    .wr(reg_wr), .wdata(reg_wdata), .stat(stat), .clr(clr), .rdata(reg_rdata));

  assign wake_s0_req = stat.me;

  a_r9_mult_in_pulse: assert property (@(posedge clk) disable iff (!warm_sync_n)
    (mult_sel != '0) |-> (plat_rst_req && reg_rdata[BIT_BOOT]));
  a_r10_wake_tracks: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    wake_s0_req == reg_rdata[BIT_ME]);
  a_r2_rsvd_write: assert property (@(posedge clk) disable iff (!rsm_sync_n)
    (reg_wr && (reg_wdata & 16'h0036) == 16'h0 && !sec_evt && !me_wake_evt && !smi_msg_evt)
      |=> $stable(reg_rdata));
endmodule

// File: tb/sim_wdt_status_ctrl.sv
module sim_wdt_status_ctrl;
  logic clk = 1'b0;
  logic rsm_n = 1'b0, hard_n = 1'b0;
  logic expire = 0, reload = 0, fetched = 1, noreb = 0, me_p = 0, smi_p = 0, wr = 0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic rst_req, wake;
  logic [3:0] mult;

  int n_chk = 0, n_fail = 0;
  string phase = "R1";

  // reference model state
  bit m_pend = 0, m_sec = 0, m_boot = 0, m_smi = 0, m_me = 0;
  int m_cnt = 0;

  always #2 clk = ~clk;

  wdt_status_ctrl u0 (
    .clk(clk), .rsm_rst_n(rsm_n), .hard_rst_n(hard_n), .wdt_expire(expire),
    .wdt_reload(reload), .cpu_fetched(fetched), .no_reboot(noreb),
    .me_wake_evt(me_p), .smi_msg_evt(smi_p), .reg_wr(wr), .reg_wdata(wdata),
    .reg_rdata(rdata), .plat_rst_req(rst_req), .wake_s0_req(wake), .mult_sel(mult));

  always @(posedge clk) begin
    bit ev, n_sec, n_boot;
    if (!rsm_n) begin
      m_pend = 0; m_sec = 0; m_boot = 0; m_smi = 0; m_me = 0; m_cnt = 0;
    end else begin
      ev     = expire && m_pend && !reload;
      n_sec  = ev || (m_sec && !(wr && wdata[1]));
      n_boot = (ev && !m_sec && !fetched) || (m_boot && !(wr && wdata[2] && !m_sec));
      m_smi  = smi_p || (m_smi && !(wr && wdata[4]));
      m_me   = me_p  || (m_me  && !(wr && wdata[5]));
      m_sec  = n_sec;
      m_boot = n_boot;
      if (!hard_n) begin
        m_pend = 0; m_cnt = 0;
      end else begin
        if (reload) m_pend = 0;
        else if (expire) m_pend = !m_pend;
        if (ev && !noreb && m_cnt == 0) m_cnt = 16;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    logic [15:0] e_rd;
    e_rd = {10'b0, m_me, m_smi, 1'b0, m_boot, m_sec, 1'b0};
    chk({phase, " model rdata"}, {16'h0, rdata}, {16'h0, e_rd});
    chk({phase, " model rst_req"}, {31'h0, rst_req}, {31'h0, m_cnt != 0});
    chk({phase, " model wake"}, {31'h0, wake}, {31'h0, m_me});
    chk({phase, " model mult"}, {28'h0, mult}, {28'h0, (m_cnt != 0 && m_boot) ? 4'hF : 4'h0});
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic exp_pulse(bit with_rld);
    expire = 1; reload = with_rld;
    @(negedge clk);
    expire = 0; reload = 0;
  endtask

  task automatic wreg(logic [15:0] v);
    wr = 1; wdata = v;
    @(negedge clk);
    wr = 0; wdata = '0;
  endtask

  task automatic measure_pulse(string req, output int width, output bit saw_f, output bit saw_z);
    width = 0; saw_f = 0; saw_z = 0;
    while (rst_req && width < 40) begin
      width++;
      if (mult == 4'hF) saw_f = 1;
      if (mult == 4'h0) saw_z = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w;
    bit sf, sz;
    repeat (3) @(negedge clk);
    rsm_n = 1; hard_n = 1;
    idle(4);
    // R1
    chk("R1 rdata", {16'h0, rdata}, 32'h0);
    chk("R1 rst_req", {31'h0, rst_req}, 32'h0);
    chk("R1 wake", {31'h0, wake}, 32'h0);
    chk("R1 mult", {28'h0, mult}, 32'h0);

    // R3 / R8 / R6 negative
    phase = "R3";
    exp_pulse(0);
    chk("R3 first expiry only arms", {16'h0, rdata}, 32'h0);
    idle(2);
    exp_pulse(0);
    chk("R3 second expiry sets bit1, R6 no boot when fetched", {16'h0, rdata}, 32'h0002);
    phase = "R8";
    measure_pulse("R8", w, sf, sz);
    chk("R8 pulse width", w, 16);
    chk("R9 no forced multiplier without boot", {31'h0, sf}, 32'h0);
    idle(3);
    chk("R8 single pulse", {31'h0, rst_req}, 32'h0);

    // R2 / R5
    phase = "R2";
    wreg(16'hFFC9);
    chk("R2 reserved write no effect", {16'h0, rdata}, 32'h0002);
    phase = "R5";
    wreg(16'h0000);
    chk("R5 zero write keeps", {16'h0, rdata}, 32'h0002);
    wreg(16'h0002);
    chk("R5 one clears", {16'h0, rdata}, 32'h0000);

    // R4
    phase = "R4";
    exp_pulse(0);
    reload = 1; @(negedge clk); reload = 0;
    exp_pulse(0);
    chk("R4 reload between expiries", {16'h0, rdata}, 32'h0);
    exp_pulse(1);
    exp_pulse(0);
    chk("R4 expiry with reload ignored", {16'h0, rdata}, 32'h0);
    exp_pulse(0);
    chk("R4 later second expiry", {16'h0, rdata}, 32'h0002);
    idle(20);
    wreg(16'h0002);

    // R6 / R9 / R7
    phase = "R6";
    fetched = 0;
    exp_pulse(0);
    exp_pulse(0);
    chk("R6 boot set", {16'h0, rdata}, 32'h0006);
    phase = "R9";
    measure_pulse("R9", w, sf, sz);
    chk("R9 forced multiplier in pulse", {30'h0, sf, sz}, 32'h2);
    chk("R8 width with boot", w, 16);
    chk("R9 mult idle after pulse", {28'h0, mult}, 32'h0);
    fetched = 1;
    phase = "R7";
    wreg(16'h0006);
    chk("R7 boot kept while sec set", {16'h0, rdata}, 32'h0004);
    wreg(16'h0004);
    chk("R7 boot clears after sec", {16'h0, rdata}, 32'h0000);

    // R8 no_reboot
    phase = "R8";
    noreb = 1;
    exp_pulse(0);
    exp_pulse(0);
    chk("R8 no_reboot flag", {16'h0, rdata}, 32'h0002);
    chk("R8 no_reboot no pulse", {31'h0, rst_req}, 32'h0);
    idle(2);
    chk("R8 no_reboot still no pulse", {31'h0, rst_req}, 32'h0);
    noreb = 0;
    wreg(16'h0002);

    // R10 / R11 / R5 set wins
    phase = "R10";
    me_p = 1; @(negedge clk); me_p = 0;
    chk("R10 me bit", {16'h0, rdata}, 32'h0020);
    chk("R10 wake req", {31'h0, wake}, 32'h1);
    phase = "R11";
    smi_p = 1; @(negedge clk); smi_p = 0;
    chk("R11 smi bit", {16'h0, rdata}, 32'h0030);
    phase = "R5";
    me_p = 1; wr = 1; wdata = 16'h0020; @(negedge clk);
    me_p = 0; wr = 0; wdata = '0;
    chk("R5 set wins over clear", {16'h0, rdata}, 32'h0030);
    wreg(16'h0010);
    chk("R11 smi clears", {16'h0, rdata}, 32'h0020);

    // R12
    phase = "R12";
    fetched = 0;
    exp_pulse(0);
    exp_pulse(0);
    fetched = 1;
    idle(3);
    chk("R12 pulse running", {31'h0, rst_req}, 32'h1);
    hard_n = 0; @(negedge clk);
    chk("R12 warm reset ends pulse", {31'h0, rst_req}, 32'h0);
    chk("R12 warm reset keeps flags", {16'h0, rdata}, 32'h0026);
    hard_n = 1; idle(4);
    chk("R12 flags after warm release", {16'h0, rdata}, 32'h0026);
    wreg(16'h0002);
    wreg(16'h0004);
    exp_pulse(0);
    hard_n = 0; @(negedge clk); hard_n = 1; idle(4);
    exp_pulse(0);
    chk("R12 warm reset disarms stage", {16'h0, rdata}, 32'h0020);
    chk("R12 no pulse after disarm", {31'h0, rst_req}, 32'h0);
    rsm_n = 0; @(negedge clk);
    chk("R12 resume reset clears", {16'h0, rdata}, 32'h0);
    chk("R12 resume reset clears wake", {31'h0, wake}, 32'h0);
    rsm_n = 1; idle(4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule